// File: doc/BRIEF.md
# Tiled Scan-Buffer Refresh Fetcher

The display image lives in a virtual canvas that is cut into square tiles of 8 words by 256 lines. Each word holds 32 pixels. The tiles of this canvas sit at arbitrary places in physical memory. This block produces the memory reads that feed the display, one scan line at a time. On each line request it steps through the horizontal tiles of the current line, from left to right. For each tile it asks an external tile table for the physical tile number. It then reads that tile's words for the line as one burst. The first read of a burst opens a row. The rest of the burst reuses the open row with column-only reads. Returned words go into an internal display FIFO, which a downstream serializer drains one word at a time.

Software programs the active width in words (up to 48 words, which is 1536 pixels) and the active height in lines. A start-of-frame pulse rewinds the line pointer to line 0. Each accepted line request fetches the line under the pointer, and the pointer moves to the next line when that fetch ends. A burst starts only when the FIFO can take a whole tile's worth of words, counting reads that are still in flight. Because of this rule a burst never stalls partway. A sticky flag reports any pop the consumer makes while the FIFO is empty.

Top module: `scanfetch_top`

## Requirements
- R1: After reset, no command and no table request is pending, the fetcher is not busy, the FIFO is empty and the underflow flag is clear.
- R2: For each tile burst, the first read has `cmd_open`=1, which opens a row. Every later read of the same burst has `cmd_open`=0, which is a column-only read.
- R3: A read address is {physical tile (8 bits), line[7:0] (8 bits), word-in-tile (3 bits)}, with the physical tile in the top bits. The word-in-tile field counts 0, 1, 2 and so on within each burst, so a row-opening read always has word-in-tile 0.
- R4: The tiles of a line are looked up in the order 0, 1, 2 and so on, using `tbl_tx` = tile index and `tbl_ty` = line[11:8]. Each burst uses the physical tile returned by its own lookup.
- R5: Each burst has min(8, words still to fetch) reads, and a line issues exactly the programmed width in words. For example, a width of 48 gives six bursts of 8, and a width of 44 ends with a burst of 4.
- R6: A burst begins only when the words already in the FIFO plus the reads still outstanding leave room for 8 more words. The FIFO therefore never overflows.
- R7: Words returned by memory leave through `disp_data` in the order they were read. A word leaves each time `disp_pop` is asserted while the FIFO is not empty.
- R8: A pop while the FIFO is empty sets `disp_underflow` on the next cycle. The flag stays set until a start-of-frame pulse clears it.
- R9: A start-of-frame pulse sets the line pointer to 0. Each completed line fetch advances the pointer by one.
- R10: A line request is ignored, with no lookup, no command and no pointer change, in any of these cases: a fetch is already in progress, the pointer is at or beyond the programmed height, or the programmed width is 0.
- R11: While `cmd_valid` is high and `cmd_ready` is low, the command stays asserted with the same address and the same open bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width_words | input | 6 | Active width in 32-pixel words |
| cfg_height | input | 12 | Active height in lines |
| frame_start | input | 1 | Start-of-frame pulse |
| line_req | input | 1 | Request to fetch the next line |
| fetch_busy | output | 1 | A line fetch is in progress |
| tbl_req | output | 1 | Tile table lookup request |
| tbl_tx | output | 4 | Horizontal tile index to look up |
| tbl_ty | output | 4 | Vertical tile index to look up |
| tbl_vld | input | 1 | Lookup result is valid |
| tbl_ptile | input | 8 | Physical tile number |
| cmd_valid | output | 1 | Memory read command valid |
| cmd_ready | input | 1 | Memory accepts the command |
| cmd_open | output | 1 | 1 = open a row first, 0 = column-only read |
| cmd_addr | output | 19 | Physical word address |
| rd_valid | input | 1 | Read data returning |
| rd_data | input | 32 | Returned word |
| disp_pop | input | 1 | Consumer takes a word |
| disp_data | output | 32 | Head word of the display FIFO |
| disp_empty | output | 1 | Display FIFO is empty |
| disp_underflow | output | 1 | Sticky flag: a pop hit an empty FIFO |

## Verification
The bench covers these line widths:

- **44 words.** Ends on a partial burst. A design that rounds up to a whole tile would issue four extra reads. A design that rounds down would drop the tail of the line.
- **48 words.** Ends exactly on a tile edge. A design that mishandles the edge would issue an empty or duplicated burst.
- **1 word.** Tested on lines past 255. A design that takes the vertical tile index from the wrong bits would look up the wrong physical tile.

A slow consumer forces the fetcher to wait for FIFO room. A design that counted only the words already stored, and not the reads in flight, would overfill the FIFO and corrupt the word stream.

Memory back-pressure holds commands mid-burst. A design that let the address move during the hold would skip or repeat words.

The bench also sends line requests that must be ignored:

- one during a busy fetch;
- one past the programmed height;
- one at zero width.

Each of these would show up as an unexpected command or as a wrong line on the next fetch.

// File: rtl/scanfetch_pkg.sv
package scanfetch_pkg;

  // Geometry of one tile and of the virtual scan canvas
  localparam int XW_W       = 3;               // word-in-tile bits
  localparam int YW_W       = 8;               // line-in-tile bits
  localparam int TX_W       = 4;               // horizontal tile index bits
  localparam int TY_W       = 4;               // vertical tile index bits
  localparam int PT_W       = 8;               // physical tile number bits
  localparam int LINE_W     = YW_W + TY_W;     // line pointer bits
  localparam int ADDR_W     = PT_W + YW_W + XW_W;
  localparam int TILE_WORDS = 1 << XW_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_ROOM,
    ST_BURST
  } walk_state_t;

  // Reads in the next burst: a full tile, or whatever is left of the line
  function automatic logic [XW_W:0] burst_len(input logic [15:0] remaining);
    if (remaining >= 16'(TILE_WORDS)) return (XW_W+1)'(TILE_WORDS);
    return remaining[XW_W:0];
  endfunction

  // Physical word address: tile number high, line in tile, then word in tile
  function automatic logic [ADDR_W-1:0] phys_addr(input logic [PT_W-1:0] ptile,
                                                  input logic [YW_W-1:0] yword,
                                                  input logic [XW_W-1:0] xword);
    return {ptile, yword, xword};
  endfunction

endpackage

// File: rtl/sf_fifo.sv
module sf_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DATA_W-1:0]            din,
  input  logic                         pop,
  output logic [DATA_W-1:0]            dout,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         underflow_evt
);
  localparam int AW   = $clog2(DEPTH);
  localparam int FC_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_q, rd_q;
  logic [FC_W-1:0]   cnt_q;
  logic              do_push, do_pop;

  assign do_push = push && (cnt_q != FC_W'(DEPTH));
  assign do_pop  = pop && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + AW'(1);
      if (do_pop)  rd_q <= rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + FC_W'(1);
        2'b01:   cnt_q <= cnt_q - FC_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout          = mem[rd_q];
  assign empty         = (cnt_q == '0);
  assign count         = cnt_q;
  assign underflow_evt = pop && (cnt_q == '0);

endmodule

// File: rtl/sf_credit.sv
module sf_credit import scanfetch_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cmd_fire,
  input  logic                              rd_valid,
  input  logic [$clog2(DEPTH+1)-1:0]        fifo_count,
  output logic [$clog2(DEPTH+1):0]          reserved,
  output logic                              room_ok
);
  localparam int FC_W  = $clog2(DEPTH+1);
  localparam int CNT_W = FC_W + 1;

  logic [CNT_W-1:0] outstanding_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding_q <= '0;
    end else begin
      case ({cmd_fire, rd_valid})
        2'b10:   outstanding_q <= outstanding_q + CNT_W'(1);
        2'b01:   outstanding_q <= outstanding_q - CNT_W'(1);
        default: outstanding_q <= outstanding_q;
      endcase
    end
  end

  // Words already stored plus words promised by reads still in flight
  assign reserved = CNT_W'(fifo_count) + outstanding_q;
  assign room_ok  = reserved <= CNT_W'(DEPTH - TILE_WORDS);

endmodule

// File: rtl/sf_walker.sv
module sf_walker import scanfetch_pkg::*; #(
  parameter int WIDTH_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WIDTH_W-1:0]  cfg_width,
  input  logic [LINE_W-1:0]   cfg_height,
  input  logic                frame_start,
  input  logic                line_req,
  input  logic                room_ok,
  output logic                tbl_req,
  output logic [TX_W-1:0]     tbl_tx,
  output logic [TY_W-1:0]     tbl_ty,
  input  logic                tbl_vld,
  input  logic [PT_W-1:0]     tbl_ptile,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic                cmd_open,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic                busy,
  output logic [LINE_W-1:0]   line_ptr
);
  walk_state_t       state_q;
  logic [LINE_W-1:0] line_q;
  logic [TX_W-1:0]   tx_q;
  logic [WIDTH_W-1:0] rem_q;
  logic [XW_W:0]     blen_q;
  logic [XW_W-1:0]   widx_q;
  logic [PT_W-1:0]   ptile_q;

  logic start_line, fire, last_word, last_tile;

  assign start_line = (state_q == ST_IDLE) && line_req &&
                      (line_q < cfg_height) && (cfg_width != '0);
  assign fire       = (state_q == ST_BURST) && cmd_ready;
  assign last_word  = ({1'b0, widx_q} + (XW_W+1)'(1)) == blen_q;
  assign last_tile  = rem_q == WIDTH_W'(blen_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      tx_q    <= '0;
      rem_q   <= '0;
      blen_q  <= '0;
      widx_q  <= '0;
      ptile_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_line) begin
            rem_q   <= cfg_width;
            tx_q    <= '0;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (tbl_vld) begin
            ptile_q <= tbl_ptile;
            blen_q  <= burst_len(16'(rem_q));
            state_q <= ST_ROOM;
          end
        end
        ST_ROOM: begin
          if (room_ok) begin
            widx_q  <= '0;
            state_q <= ST_BURST;
          end
        end
        ST_BURST: begin
          if (fire) begin
            if (last_word) begin
              rem_q <= rem_q - WIDTH_W'(blen_q);
              if (last_tile) begin
                state_q <= ST_IDLE;
              end else begin
                tx_q    <= tx_q + TX_W'(1);
                state_q <= ST_LOOK;
              end
            end else begin
              widx_q <= widx_q + XW_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase

      // The frame pulse takes priority over the end-of-line advance
      if (frame_start)
        line_q <= '0;
      else if (fire && last_word && last_tile)
        line_q <= line_q + LINE_W'(1);
    end
  end

  assign tbl_req   = (state_q == ST_LOOK);
  assign tbl_tx    = tx_q;
  assign tbl_ty    = line_q[YW_W +: TY_W];
  assign cmd_valid = (state_q == ST_BURST);
  assign cmd_open  = (state_q == ST_BURST) && (widx_q == '0);
  assign cmd_addr  = phys_addr(ptile_q, line_q[YW_W-1:0], widx_q);
  assign busy      = (state_q != ST_IDLE);
  assign line_ptr  = line_q;

endmodule

// File: rtl/scanfetch_top.sv
module scanfetch_top import scanfetch_pkg::*; #(
  parameter int WIDTH_W    = 6,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WIDTH_W-1:0]  cfg_width_words,
  input  logic [LINE_W-1:0]   cfg_height,
  input  logic                frame_start,
  input  logic                line_req,
  output logic                fetch_busy,
  output logic                tbl_req,
  output logic [TX_W-1:0]     tbl_tx,
  output logic [TY_W-1:0]     tbl_ty,
  input  logic                tbl_vld,
  input  logic [PT_W-1:0]     tbl_ptile,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic                cmd_open,
  output logic [ADDR_W-1:0]   cmd_addr,
  input  logic                rd_valid,
  input  logic [DATA_W-1:0]   rd_data,
  input  logic                disp_pop,
  output logic [DATA_W-1:0]   disp_data,
  output logic                disp_empty,
  output logic                disp_underflow
);
  localparam int FC_W = $clog2(FIFO_DEPTH+1);

  logic [FC_W-1:0]   fifo_count;
  logic [FC_W:0]     reserved;
  logic              room_ok;
  logic              underflow_evt;
  logic [LINE_W-1:0] line_ptr;
  logic              underflow_q;

  sf_walker #(.WIDTH_W(WIDTH_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_width  (cfg_width_words),
    .cfg_height (cfg_height),
    .frame_start(frame_start),
    .line_req   (line_req),
    .room_ok    (room_ok),
    .tbl_req    (tbl_req),
    .tbl_tx     (tbl_tx),
    .tbl_ty     (tbl_ty),
    .tbl_vld    (tbl_vld),
    .tbl_ptile  (tbl_ptile),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_open   (cmd_open),
    .cmd_addr   (cmd_addr),
    .busy       (fetch_busy),
    .line_ptr   (line_ptr)
  );

  sf_credit #(.DEPTH(FIFO_DEPTH)) u_credit (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_fire  (cmd_valid && cmd_ready),
    .rd_valid  (rd_valid),
    .fifo_count(fifo_count),
    .reserved  (reserved),
    .room_ok   (room_ok)
  );

  sf_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk          (clk),
    .rst_n        (rst_n),
    .push         (rd_valid),
    .din          (rd_data),
    .pop          (disp_pop),
    .dout         (disp_data),
    .empty        (disp_empty),
    .count        (fifo_count),
    .underflow_evt(underflow_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)             underflow_q <= 1'b0;
    else if (frame_start)   underflow_q <= 1'b0;
    else if (underflow_evt) underflow_q <= 1'b1;
  end

  assign disp_underflow = underflow_q;

endmodule

// File: rtl/sf_checks.sv
module sf_checks #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 19,
  parameter int LINE_W = 12,
  parameter int TY_W   = 4,
  parameter int RES_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_open,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              tbl_req,
  input logic [TY_W-1:0]   tbl_ty,
  input logic [LINE_W-1:0] line_ptr,
  input logic              disp_pop,
  input logic              disp_empty,
  input logic              disp_underflow,
  input logic [RES_W-1:0]  reserved
);

  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_open));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reserved <= RES_W'(DEPTH));

  // R8
  underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_pop && disp_empty && !frame_start |=> disp_underflow);

  // R3
  open_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_open |-> cmd_addr[2:0] == 3'd0);

  // R9
  frame_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> line_ptr == '0);

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start && !(cmd_valid && cmd_ready) |=> $stable(line_ptr));

  // R4
  lookup_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req |-> tbl_ty == line_ptr[LINE_W-1 -: TY_W]);

endmodule

bind scanfetch_top sf_checks #(
  .DEPTH (FIFO_DEPTH),
  .ADDR_W(scanfetch_pkg::ADDR_W),
  .LINE_W(scanfetch_pkg::LINE_W),
  .TY_W  (scanfetch_pkg::TY_W),
  .RES_W ($clog2(FIFO_DEPTH+1)+1)
) u_sf_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_start   (frame_start),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_open      (cmd_open),
  .cmd_addr      (cmd_addr),
  .tbl_req       (tbl_req),
  .tbl_ty        (tbl_ty),
  .line_ptr      (line_ptr),
  .disp_pop      (disp_pop),
  .disp_empty    (disp_empty),
  .disp_underflow(disp_underflow),
  .reserved      (reserved)
);

// File: tb/test_scanfetch_top.sv
module test_scanfetch_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_width_words = '0;
  logic [11:0] cfg_height = '0;
  logic        frame_start = 1'b0, line_req = 1'b0;
  logic        fetch_busy, tbl_req, tbl_vld = 1'b0;
  logic [3:0]  tbl_tx, tbl_ty;
  logic [7:0]  tbl_ptile = '0;
  logic        cmd_valid, cmd_ready = 1'b0, cmd_open;
  logic [18:0] cmd_addr;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0, disp_data;
  logic        disp_pop = 1'b0, disp_empty, disp_underflow;

  scanfetch_top i_scanfetch_top (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, ln_model = 0;
  bit stall_mode = 0, pop_en = 1, pop_force = 0, done = 0;
  int pop_div = 1;
  logic [19:0] exp_cmd[$];
  logic [31:0] exp_dat[$], mq[$];
  int due[$];

  function automatic logic [7:0] ptile_fn(input logic [3:0] tx, input logic [3:0] ty);
    return {ty, tx} ^ 8'hA5;
  endfunction
  function automatic logic [31:0] data_fn(input logic [18:0] a);
    return {~a[12:0], a};
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor and environment models, all acting at the falling edge
  initial begin
    int occ = 0;
    int res;
    bit popped = 0, pop_was_empty = 0, hold = 0;
    logic [19:0] held = '0, got, want;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) continue;
      if (rd_valid) occ++;
      if (popped && !pop_was_empty) occ--;
      res = occ + mq.size();
      // R11: a held command keeps its value
      if (hold) check(cmd_valid && {cmd_open, cmd_addr} == held, "R11", {cmd_open, cmd_addr}, held);
      // tile table model, one cycle per answer
      tbl_vld = tbl_req && !tbl_vld;
      tbl_ptile = ptile_fn(tbl_tx, tbl_ty);
      cmd_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
      // memory returns after a fixed delay
      if (mq.size() > 0 && due[0] <= cyc) begin
        rd_valid = 1'b1; rd_data = mq.pop_front(); void'(due.pop_front());
      end else rd_valid = 1'b0;
      // consumer (R7)
      popped = (pop_en && !disp_empty && (cyc % pop_div == 0)) || pop_force;
      pop_force = 0;
      pop_was_empty = disp_empty;
      if (popped && !disp_empty) begin
        if (exp_dat.size() == 0) check(0, "R7", disp_data, 0);
        else begin want = 0; check(disp_data == exp_dat[0], "R7", disp_data, exp_dat[0]); void'(exp_dat.pop_front()); end
      end
      disp_pop = popped;
      // command scoreboard (R2 R3 R4 R5 R6)
      hold = cmd_valid && !cmd_ready;
      held = {cmd_open, cmd_addr};
      if (cmd_valid && cmd_ready) begin
        got = {cmd_open, cmd_addr};
        if (exp_cmd.size() == 0) check(0, "R10 unexpected command", got, 0);
        else begin
          want = exp_cmd.pop_front();
          check(got == want, "R2/R3/R4 command", got, want);
        end
        if (cmd_open) check(res <= DEPTH - 8, "R6 room", res, DEPTH - 8);
        mq.push_back(data_fn(cmd_addr));
        due.push_back(cyc + 3);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    ln_model = 0;
  endtask

  // Driver: expected commands and words for one line, then the request
  task automatic do_line(input int w, input bit dup_req);
    int t = 0;
    int left = w;
    while (left > 0) begin
      int n = (left >= 8) ? 8 : left;
      for (int k = 0; k < n; k++) begin
        logic [18:0] a = {ptile_fn(4'(t), 4'(ln_model >> 8)), 8'(ln_model), 3'(k)};
        exp_cmd.push_back({(k == 0), a});
        exp_dat.push_back(data_fn(a));
      end
      left -= n; t++;
    end
    @(negedge clk); line_req = 1'b1;
    @(negedge clk); line_req = 1'b0;
    if (dup_req) begin
      repeat (2) @(negedge clk);
      line_req = 1'b1; @(negedge clk); line_req = 1'b0;
    end
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (exp_cmd.size() == 0 && !fetch_busy) break;
    end
    check(exp_cmd.size() == 0, "R5 line length", exp_cmd.size(), 0);
    ln_model++;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && exp_dat.size() > 0; i++) @(negedge clk);
    check(exp_dat.size() == 0, "R7 drained", exp_dat.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!cmd_valid && !tbl_req && !fetch_busy, "R1 idle", {cmd_valid, tbl_req, fetch_busy}, 0);
    check(disp_empty && !disp_underflow, "R1 fifo", {disp_empty, disp_underflow}, 2'b10);
    // R8: pop on empty sets the sticky flag, frame pulse clears it
    pop_force = 1;
    repeat (2) @(negedge clk);
    check(disp_underflow, "R8 set", disp_underflow, 1);
    repeat (3) @(negedge clk);
    check(disp_underflow, "R8 sticky", disp_underflow, 1);
    cfg_width_words = 6'd48; cfg_height = 12'd1152;
    pulse_frame();
    check(!disp_underflow, "R8 clear", disp_underflow, 0);
    // R2 R3 R4 R5 at several widths
    do_line(48, 0);
    cfg_width_words = 6'd44; do_line(44, 0);
    cfg_width_words = 6'd40; do_line(40, 0);
    cfg_width_words = 6'd3;  do_line(3, 0);
    drain();
    // R11 with memory back-pressure
    stall_mode = 1; cfg_width_words = 6'd48; do_line(48, 0); stall_mode = 0;
    drain();
    // R6 with a slow consumer
    pop_div = 5; do_line(48, 0); drain(); pop_div = 1;
    // R10 request while busy is ignored
    do_line(48, 1);
    drain();
    // R10 zero width is ignored
    cfg_width_words = 6'd0;
    @(negedge clk); line_req = 1'b1; @(negedge clk); line_req = 1'b0;
    repeat (5) @(negedge clk);
    check(!fetch_busy, "R10 zero width", fetch_busy, 0);
    // R4 R9 lines past the first tile row
    cfg_width_words = 6'd1;
    while (ln_model < 260) do_line(1, 0);
    drain();
    // R9 frame rewinds to line 0
    cfg_width_words = 6'd8;
    pulse_frame();
    do_line(8, 0);
    // R10 height limit
    cfg_height = 12'd2;
    do_line(8, 0);
    @(negedge clk); line_req = 1'b1; @(negedge clk); line_req = 1'b0;
    repeat (10) @(negedge clk);
    check(!fetch_busy && !tbl_req, "R10 height", {fetch_busy, tbl_req}, 0);
    drain();
    done = 1;
    finish_run();
  end

endmodule